// File: doc/BRIEF.md
# Capture/Compare Timer

A free-running 32-bit up-counter advanced by a prescaled tick, paired with a parameterised bank of capture/compare channels (four or six). Each channel holds a value that software can write, or that a capture task fills with the current count. When the counter steps onto a channel's value, the channel raises a sticky flag and emits a one-cycle event pulse. Per-channel shortcuts can clear or halt the counter on a match. A single level interrupt combines the flags with their enables.

The block is driven by a word-addressed write/read register port and, in parallel, by hardware task inputs from an event-routing fabric. Its event outputs go back to that fabric. The tick comes from a base-rate enable (`base_en_i`, nominally 16 MHz) divided by 2^p, where the prescaler value p ranges from 0 to 9.

Word address map (address = group[5:3], index[2:0]):
- Group 0 holds the control registers, by index: 0 start, 1 stop, 2 clear, 3 prescaler, 4 shortcuts, 5 interrupt-enable set, 6 interrupt-enable clear.
- Group 1 holds the capture strobes. Group 2 holds the compare values. Group 3 holds the event flags. In each of these the index is the channel number.

Top module: `cc_timer`

## Requirements
- R1: After reset the timer is stopped with count 0, the prescaler reads 4, and the shortcuts, interrupt enables, compare values, flags, event outputs and `irq_o` are all 0.
- R2: A start, stop or clear task can be given either as a register write with bit 0 set to 1 (addresses 0, 1, 2) or as a pulse on `hw_start_i`, `hw_stop_i` or `hw_clear_i`. Stop wins over start in the same cycle. Clear sets the count to 0 and wins over a tick in the same cycle. A stopped counter holds its value.
- R3: The prescaler register (address 3) sets p. While the timer runs, the counter advances once every 2^p cycles in which `base_en_i` is high. A write with a value above 9, or a write while the timer runs, leaves the prescaler unchanged.
- R4: The counter wraps from its all-ones value to 0 on the next tick.
- R5: A capture task on channel n (a write of 1 to address 8+n, or a pulse on `hw_capture_i[n]`) copies the present count into that channel's value. A capture wins over a register write to the same channel in the same cycle.
- R6: Channel n's flag (address 24+n, bit 0) is set in the cycle in which a tick moves the counter onto the channel's value (address 16+n). The flag stays set until software writes a 0 to it. Writing a 1 has no effect.
- R7: `evt_compare_o[n]` is high for exactly the one cycle in which flag n is set by a match.
- R8: Shortcut bit n (address 4) makes a match on channel n clear the counter, so the count is 0 one cycle after the match cycle.
- R9: Shortcut bit 8+n makes a match on channel n stop the timer, leaving the count equal to the matched value.
- R10: Interrupt-enable bit 16+n is set by writing 1 to that bit at address 5 and cleared by writing 1 to that bit at address 6. Both addresses read back the enables. `irq_o` is high exactly when some flag n and its enable bit 16+n are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| base_en_i | input | 1 | Base-rate enable feeding the prescaler |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Word address for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational from address) |
| hw_start_i | input | 1 | Hardware start task |
| hw_stop_i | input | 1 | Hardware stop task |
| hw_clear_i | input | 1 | Hardware clear task |
| hw_capture_i | input | NUM_CH | Hardware capture task per channel |
| evt_compare_o | output | NUM_CH | One-cycle compare event per channel |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench runs the counter for exact numbers of base cycles at several prescaler values. A divider that is off by one, or that counts before the first edge, returns the wrong count. It also issues a clear together with a stop while ticking, a stop together with a start, and a capture together with a register write. A design with the wrong priority leaves 1, keeps running, or stores the written pattern. The bench watches the event output cycle by cycle and checks that the count is 1 with the clear shortcut and 3 with the stop shortcut. A design that matched one tick late, or stopped one tick late, shows 4 or a shifted pulse. A narrow second instance is run past the all-ones value, so a counter that saturates or misses the wrap match fails.

// File: rtl/cct_pkg.sv
// Shared constants of the capture/compare timer: address groups, control
// register indices and bit offsets of the per-channel lanes.
package cct_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 6;

    localparam logic [2:0] GRP_CTRL = 3'd0;
    localparam logic [2:0] GRP_CAP  = 3'd1;
    localparam logic [2:0] GRP_CMP  = 3'd2;
    localparam logic [2:0] GRP_EVT  = 3'd3;

    localparam logic [2:0] CTL_START  = 3'd0;
    localparam logic [2:0] CTL_STOP   = 3'd1;
    localparam logic [2:0] CTL_CLEAR  = 3'd2;
    localparam logic [2:0] CTL_PSC    = 3'd3;
    localparam logic [2:0] CTL_SHORT  = 3'd4;
    localparam logic [2:0] CTL_INTSET = 3'd5;
    localparam logic [2:0] CTL_INTCLR = 3'd6;

    localparam int SC_STOP_OFS = 8;
    localparam int INT_OFS     = 16;
endpackage

// File: rtl/cct_prescaler.sv
// Prescaler: divides the base-rate enable by 2^psc while the timer runs.
// Assumes psc_i <= DIV_W. The divider is cleared together with the counter.
module cct_prescaler #(
    parameter int PSC_W = 4,
    parameter int DIV_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             base_en_i,
    input  logic             clear_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Low psc bits of the divider that must all be one for a tick.
    always_comb mask = ~({DIV_W{1'b1}} << psc_i);

    assign tick_o = run_i && base_en_i && ((div_q & mask) == mask);

    // Divider advances on each enabled base cycle while running.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                  div_q <= '0;
        else if (clear_i)             div_q <= '0;
        else if (run_i && base_en_i)  div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/cct_counter.sv
// Counter core: run state and the up-counter. Stop beats start, clear beats
// a tick. Assumes all task inputs are single-cycle strobes.
module cct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             clear_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             running_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Run state with stop priority.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      running_o <= 1'b0;
        else if (stop_i)  running_o <= 1'b0;
        else if (start_i) running_o <= 1'b1;
    end

    // Count register with clear priority; wraps naturally.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      cnt_o <= '0;
        else if (clear_i) cnt_o <= '0;
        else if (tick_i)  cnt_o <= cnt_o + ONE;
    end
endmodule

// File: rtl/cct_channel.sv
// One capture/compare channel: value register, sticky flag and event pulse.
// A match is a tick that moves the counter onto the stored value. Capture
// beats a write; a match beats a software flag clear.
module cct_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_val_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic             cap_i,
    input  logic             flag_clr_i,
    output logic             hit_o,
    output logic             flag_o,
    output logic             evt_o,
    output logic [CNT_W-1:0] value_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_next;

    assign cnt_next = cnt_i + ONE;
    assign hit_o    = tick_i && (cnt_next == value_o);

    // Channel value: capture first, then software write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       value_o <= '0;
        else if (cap_i)    value_o <= cnt_i;
        else if (wr_val_i) value_o <= val_i;
    end

    // Sticky flag and its one-cycle event pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_o <= 1'b0;
            evt_o  <= 1'b0;
        end else begin
            evt_o <= hit_o;
            if (hit_o)           flag_o <= 1'b1;
            else if (flag_clr_i) flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/cc_timer.sv
// Capture/compare timer top: register decode, shortcut and interrupt
// registers, prescaler, counter and NUM_CH channels. Assumes NUM_CH is 4 or
// 6 (at most 8), CNT_W <= 32 and PSC_MAX < 2^PSC_W.
module cc_timer #(
    parameter int NUM_CH  = 4,
    parameter int CNT_W   = 32,
    parameter int PSC_W   = 4,
    parameter int PSC_MAX = 9,
    parameter int PSC_RST = 4
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        base_en_i,
    input  logic                        reg_we_i,
    input  logic [cct_pkg::ADDR_W-1:0]  reg_addr_i,
    input  logic [cct_pkg::REG_W-1:0]   reg_wdata_i,
    output logic [cct_pkg::REG_W-1:0]   reg_rdata_o,
    input  logic                        hw_start_i,
    input  logic                        hw_stop_i,
    input  logic                        hw_clear_i,
    input  logic [NUM_CH-1:0]           hw_capture_i,
    output logic [NUM_CH-1:0]           evt_compare_o,
    output logic                        irq_o
);
    import cct_pkg::*;

    localparam int DIV_W = (PSC_MAX > 0) ? PSC_MAX : 1;

    function automatic logic [REG_W-1:0] lane_mask(input int ofs);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_CH; i++) m[ofs+i] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] SHORT_MASK = lane_mask(0) | lane_mask(SC_STOP_OFS);
    localparam logic [REG_W-1:0] INT_MASK   = lane_mask(INT_OFS);

    logic [2:0]        grp, idx;
    logic              ctl_wr, start_any, stop_any, clr_task, clr_any;
    logic              sc_clr, sc_stop, tick, running_q, psc_ok;
    logic [CNT_W-1:0]  cnt_q;
    logic [PSC_W-1:0]  psc_q;
    logic [REG_W-1:0]  shorts_q, inten_q;
    logic [NUM_CH-1:0] hit_vec, flag_vec, evt_vec, cap_vec, cmp_wr, flag_clr;
    logic [CNT_W-1:0]  val_arr [NUM_CH];

    assign grp    = reg_addr_i[5:3];
    assign idx    = reg_addr_i[2:0];
    assign ctl_wr = reg_we_i && (grp == GRP_CTRL);

    // Task sources: register strobes OR hardware inputs OR shortcuts.
    always_comb begin
        sc_clr    = |(evt_vec & shorts_q[NUM_CH-1:0]);
        sc_stop   = |(hit_vec & shorts_q[SC_STOP_OFS +: NUM_CH]);
        start_any = hw_start_i || (ctl_wr && idx == CTL_START && reg_wdata_i[0]);
        clr_task  = hw_clear_i || (ctl_wr && idx == CTL_CLEAR && reg_wdata_i[0]);
        stop_any  = hw_stop_i  || (ctl_wr && idx == CTL_STOP  && reg_wdata_i[0]) || sc_stop;
        clr_any   = clr_task || sc_clr;
    end

    // Per-channel write, capture and flag-clear decode.
    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            cap_vec[n]  = hw_capture_i[n] ||
                          (reg_we_i && grp == GRP_CAP && idx == 3'(n) && reg_wdata_i[0]);
            cmp_wr[n]   = reg_we_i && grp == GRP_CMP && idx == 3'(n);
            flag_clr[n] = reg_we_i && grp == GRP_EVT && idx == 3'(n) && !reg_wdata_i[0];
        end
    end

    assign psc_ok = (reg_wdata_i[REG_W-1:PSC_W] == '0) &&
                    (reg_wdata_i[PSC_W-1:0] <= PSC_W'(PSC_MAX));

    // Configuration registers: prescaler (locked while running), shortcuts, enables.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            psc_q    <= PSC_W'(PSC_RST);
            shorts_q <= '0;
            inten_q  <= '0;
        end else if (ctl_wr) begin
            if (idx == CTL_PSC && !running_q && psc_ok) psc_q <= reg_wdata_i[PSC_W-1:0];
            if (idx == CTL_SHORT)  shorts_q <= reg_wdata_i & SHORT_MASK;
            if (idx == CTL_INTSET) inten_q  <= inten_q | (reg_wdata_i & INT_MASK);
            if (idx == CTL_INTCLR) inten_q  <= inten_q & ~(reg_wdata_i & INT_MASK);
        end
    end

    cct_prescaler #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_psc (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(running_q), .base_en_i(base_en_i),
        .clear_i(clr_any), .psc_i(psc_q), .tick_o(tick)
    );

    cct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_any), .stop_i(stop_any),
        .clear_i(clr_any), .tick_i(tick), .cnt_o(cnt_q), .running_o(running_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cct_channel #(.CNT_W(CNT_W)) u_ch (
            .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .cnt_i(cnt_q),
            .wr_val_i(cmp_wr[g]), .val_i(reg_wdata_i[CNT_W-1:0]), .cap_i(cap_vec[g]),
            .flag_clr_i(flag_clr[g]), .hit_o(hit_vec[g]), .flag_o(flag_vec[g]),
            .evt_o(evt_vec[g]), .value_o(val_arr[g])
        );
    end

    assign evt_compare_o = evt_vec;
    assign irq_o         = |(flag_vec & inten_q[INT_OFS +: NUM_CH]);

    // Read mux selected by the address alone.
    always_comb begin
        reg_rdata_o = '0;
        case (grp)
            GRP_CTRL: begin
                if (idx == CTL_PSC)   reg_rdata_o = REG_W'(psc_q);
                if (idx == CTL_SHORT) reg_rdata_o = shorts_q;
                if (idx == CTL_INTSET || idx == CTL_INTCLR) reg_rdata_o = inten_q;
            end
            GRP_CMP: for (int n = 0; n < NUM_CH; n++)
                if (idx == 3'(n)) reg_rdata_o = REG_W'(val_arr[n]);
            GRP_EVT: for (int n = 0; n < NUM_CH; n++)
                if (idx == 3'(n)) reg_rdata_o[0] = flag_vec[n];
            default: reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/cct_checker.sv
// Temporal checks on the timer, attached to every cc_timer by bind.
module cct_checker #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int PSC_W  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_CH-1:0] evt_vec,
    input logic [NUM_CH-1:0] flag_vec,
    input logic [31:0]       inten_q,
    input logic [31:0]       shorts_q,
    input logic              running_q,
    input logic [PSC_W-1:0]  psc_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              clr_any,
    input logic              tick,
    input logic              irq_o
);
    AST_EVT_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_vec & ~flag_vec) == '0); // R7
    AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_vec != '0) |=> ((evt_vec & $past(evt_vec)) == '0)); // R7
    AST_PSC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_q |=> $stable(psc_q)); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_any |=> (cnt_q == '0)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running_q && !clr_any) |=> $stable(cnt_q)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && cnt_q == '1) |=> (cnt_q == '0)); // R4
    AST_SHORT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evt_vec & shorts_q[NUM_CH-1:0]) != '0) |=> (cnt_q == '0)); // R8
    AST_SHORT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evt_vec & $past(shorts_q[8 +: NUM_CH])) != '0) |-> !running_q); // R9
    AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (flag_vec != '0 && inten_q != '0)); // R10
endmodule

bind cc_timer cct_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_vec(evt_vec), .flag_vec(flag_vec),
    .inten_q(inten_q), .shorts_q(shorts_q), .running_q(running_q), .psc_q(psc_q),
    .cnt_q(cnt_q), .clr_any(clr_any), .tick(tick), .irq_o(irq_o)
);

// File: tb/tb_cc_timer.sv
`timescale 1ns/1ps
module tb_cc_timer;
    localparam int NCH = 4;

    typedef struct packed { int psc; int ticks; int expc; } vec_t;
    localparam vec_t VEC [7] = '{
        '{0, 5, 5}, '{1, 8, 4}, '{1, 9, 4}, '{2, 11, 2},
        '{3, 16, 2}, '{4, 47, 2}, '{9, 600, 1}
    };

    logic clk = 1'b0, rst_n = 1'b0, base_en = 1'b1;
    logic reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, rdata, rdata_w;
    logic hw_start = 1'b0, hw_stop = 1'b0, hw_clear = 1'b0;
    logic [NCH-1:0] hw_cap = '0, evt, evt_w;
    logic irq, irq_w;
    logic [31:0] rv, rvw;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cc_timer #(.NUM_CH(NCH)) dut (
        .clk_i(clk), .rst_ni(rst_n), .base_en_i(base_en), .reg_we_i(reg_we),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
        .hw_start_i(hw_start), .hw_stop_i(hw_stop), .hw_clear_i(hw_clear),
        .hw_capture_i(hw_cap), .evt_compare_o(evt), .irq_o(irq));

    cc_timer #(.NUM_CH(NCH), .CNT_W(8)) dut_wrap (
        .clk_i(clk), .rst_ni(rst_n), .base_en_i(base_en), .reg_we_i(reg_we),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata_w),
        .hw_start_i(hw_start), .hw_stop_i(hw_stop), .hw_clear_i(hw_clear),
        .hw_capture_i(hw_cap), .evt_compare_o(evt_w), .irq_o(irq_w));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; applies at the next posedge, returns at the following negedge.
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a);
        reg_addr = a;
        #1;
        rv = rdata; rvw = rdata_w;
    endtask

    // Capture into channel 3 and read it back.
    task automatic read_cnt();
        wr(6'd11, 32'd1);
        rd(6'd19);
    endtask

    // Start at edge E0, stop at edge Ek: k potential ticks.
    task automatic run_ticks(input int k);
        hw_start = 1'b1;
        @(negedge clk);
        hw_start = 1'b0;
        repeat (k - 1) @(negedge clk);
        hw_stop = 1'b1;
        @(negedge clk);
        hw_stop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'd3);  check("R1 prescaler", rv, 32'd4);
        rd(6'd4);  check("R1 shortcuts", rv, 32'd0);
        rd(6'd5);  check("R1 int enable", rv, 32'd0);
        for (int n = 0; n < NCH; n++) begin
            rd(6'(16 + n)); check("R1 compare value", rv, 32'd0);
            rd(6'(24 + n)); check("R1 flag", rv, 32'd0);
        end
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 events", {28'd0, evt}, 32'd0);
        read_cnt(); check("R1 count", rv, 32'd0);

        // R3 prescaler table
        for (int i = 0; i < 7; i++) begin
            wr(6'd2, 32'd1);
            wr(6'd3, 32'(VEC[i].psc));
            run_ticks(VEC[i].ticks);
            read_cnt();
            check($sformatf("R3 vector %0d", i), rv, 32'(VEC[i].expc));
        end

        // R3 ignored prescaler writes
        wr(6'd3, 32'd2);
        wr(6'd3, 32'd12);  rd(6'd3); check("R3 out-of-range write", rv, 32'd2);
        wr(6'd0, 32'd1);
        wr(6'd3, 32'd0);   rd(6'd3); check("R3 write while running", rv, 32'd2);
        wr(6'd1, 32'd1);

        // R2 stop beats start
        wr(6'd3, 32'd0);
        wr(6'd2, 32'd1);
        hw_start = 1'b1; hw_stop = 1'b1;
        @(negedge clk);
        hw_start = 1'b0; hw_stop = 1'b0;
        repeat (5) @(negedge clk);
        read_cnt(); check("R2 stop wins over start", rv, 32'd0);

        // R2 register start then stop: one tick
        wr(6'd2, 32'd1);
        wr(6'd0, 32'd1);
        wr(6'd1, 32'd1);
        read_cnt(); check("R2 register start/stop", rv, 32'd1);

        // R2 clear beats tick
        wr(6'd2, 32'd1);
        hw_start = 1'b1;
        @(negedge clk);
        hw_start = 1'b0;
        repeat (3) @(negedge clk);
        hw_clear = 1'b1; hw_stop = 1'b1;
        @(negedge clk);
        hw_clear = 1'b0; hw_stop = 1'b0;
        read_cnt(); check("R2 clear wins over tick", rv, 32'd0);

        // R5 capture beats write
        wr(6'd2, 32'd1);
        run_ticks(7);
        reg_we = 1'b1; reg_addr = 6'd19; reg_wdata = 32'h0000_AAAA; hw_cap = 4'b1010;
        @(negedge clk);
        reg_we = 1'b0; hw_cap = '0;
        rd(6'd19); check("R5 capture beats write", rv, 32'd7);
        rd(6'd17); check("R5 hardware capture", rv, 32'd7);
        wr(6'd17, 32'd0);

        // R6/R7 compare event timing
        for (int n = 0; n < NCH; n++) wr(6'(24 + n), 32'd0);
        wr(6'd16, 32'd3);
        wr(6'd2, 32'd1);
        hw_start = 1'b1;
        @(negedge clk);
        hw_start = 1'b0;
        for (int j = 0; j < 6; j++) begin
            check($sformatf("R7 event cycle %0d", j), {31'd0, evt[0]}, {31'd0, j == 3});
            if (j < 5) @(negedge clk);
        end
        hw_stop = 1'b1;
        @(negedge clk);
        hw_stop = 1'b0;
        rd(6'd24); check("R6 flag set", rv, 32'd1);
        check("R10 irq disabled", {31'd0, irq}, 32'd0);
        wr(6'd24, 32'd1);
        rd(6'd24); check("R6 write one ignored", rv, 32'd1);
        wr(6'd5, 32'h0001_0000);
        check("R10 irq enabled", {31'd0, irq}, 32'd1);
        rd(6'd6); check("R10 enable readback", rv, 32'h0001_0000);
        wr(6'd6, 32'h0001_0000);
        check("R10 irq after clear", {31'd0, irq}, 32'd0);
        wr(6'd5, 32'h0001_0000);
        wr(6'd24, 32'd0);
        rd(6'd24); check("R6 flag cleared", rv, 32'd0);
        check("R10 irq follows flag", {31'd0, irq}, 32'd0);
        wr(6'd6, 32'hFFFF_FFFF);

        // R8 clear shortcut
        wr(6'd4, 32'h0000_0001);
        rd(6'd4); check("R8 shortcut readback", rv, 32'h1);
        wr(6'd2, 32'd1);
        run_ticks(5);
        read_cnt(); check("R8 clear shortcut", rv, 32'd1);

        // R9 stop shortcut
        wr(6'd4, 32'h0000_0100);
        wr(6'd2, 32'd1);
        run_ticks(10);
        read_cnt(); check("R9 stop shortcut", rv, 32'd3);

        // R4 wrap on the narrow instance
        wr(6'd4, 32'd0);
        wr(6'd16, 32'd0);
        wr(6'd24, 32'd0);
        wr(6'd2, 32'd1);
        run_ticks(258);
        read_cnt();
        check("R4 wide count", rv, 32'd258);
        check("R4 narrow wrap", rvw, 32'd2);
        rd(6'd24);
        check("R4 wrap match flag", rvw, 32'd1);
        check("R6 no false match", rv, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule